// File: doc/BRIEF.md
# Banked Memory Window Address Translator

This block turns logical addresses into physical addresses in a 24-bit address space. Two 128 KiB apertures, one at 0x80000 and one at 0xA0000, can each be pointed at any 128 KiB-aligned region of physical memory. Each aperture has a byte-wide base register. The block also has a DMA gate register. All three registers sit behind a small I/O port that can be written and read. Every translated address comes with a valid flag, which drops when the physical address lands at or above the upper-memory cutoff.

CPU lookups are combinational. A separate DMA sequencer takes one request at a time and translates each access it issues. When the gate is set, it clears physical address line 20. A 16-bit DMA transfer at an odd address becomes two byte accesses, and the sequencer reports the summed wait count once both bytes finish.

A change of either window base produces a single-cycle remap strobe, so neighbouring decode tables can be rebuilt.

Top module: `mem_window_xlat`

## Requirements
- R1: A window register write keeps bits 7:1 of the data byte and forces bit 0 to zero. The base becomes (data AND 0xFE) << 16. A read returns base >> 16.
- R2: After reset, window 0 reads 0x08 (base 0x80000) and window 1 reads 0x0A (base 0xA0000). With HIRES=1 they read 0x10 and 0x12. The DMA gate register reads 0xFE.
- R3: Logical addresses below 0x80000 are passed through unchanged.
- R4: Logical addresses 0x80000 to 0x9FFFF map to (address AND 0x1FFFF) OR window-0 base.
- R5: Logical addresses 0xA0000 to 0xBFFFF map to (address AND 0x1FFFF) OR window-1 base.
- R6: Logical addresses from 0xC0000 upward are passed through unchanged.
- R7: The valid flag is low exactly when the physical address is 0xFA0000 or above.
- R8: The DMA gate register stores and returns the whole written byte. While its bit 2 is 1, bit 20 of every DMA physical address is forced to 0. While bit 2 is 0, bit 20 passes through.
- R9: A 16-bit DMA transfer at an odd address becomes two byte accesses: first at addr, then at addr+1. A 16-bit transfer at an even address is one word access (mem_wide_o=1). An 8-bit transfer is one byte access.
- R10: When a DMA transfer completes, dma_done_o pulses for one cycle and dma_wait_o holds the sum of the mem_wait_i values of all its accesses.
- R11: remap_o pulses for one cycle, in the cycle after a window write that changes that window's base. A write that leaves the base unchanged gives no pulse, and this includes a write that differs only in bit 0.
- R12: io_sel_i selects the register: 0 is the DMA gate, 1 is window 0, 2 is window 1. Code 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sel_i | input | 2 | Register select |
| io_wr_i | input | 1 | Register write strobe |
| io_wdata_i | input | 8 | Register write data |
| io_rdata_o | output | 8 | Read data of the selected register |
| remap_o | output | 1 | One-cycle strobe on a window base change |
| cpu_addr_i | input | 24 | CPU logical address |
| cpu_paddr_o | output | 24 | CPU physical address |
| cpu_valid_o | output | 1 | CPU physical address is below the cutoff |
| dma_req_i | input | 1 | DMA transfer request, taken when the sequencer is idle |
| dma_wide_i | input | 1 | DMA transfer is 16 bits |
| dma_addr_i | input | 24 | DMA logical address |
| dma_busy_o | output | 1 | Sequencer is busy with a transfer |
| dma_done_o | output | 1 | One-cycle pulse when a transfer completes |
| dma_wait_o | output | WAIT_W+1 | Summed wait count of the finished transfer |
| mem_req_o | output | 1 | Memory access request |
| mem_addr_o | output | 24 | Physical address of the memory access |
| mem_wide_o | output | 1 | Memory access is a word access |
| mem_valid_o | output | 1 | Memory access address is below the cutoff |
| mem_ack_i | input | 1 | Memory access accepted |
| mem_wait_i | input | WAIT_W | Wait count of the accepted access |

## Verification
A wrong window register shows up as a wrong upper part of cpu_paddr_o as soon as the register is written, and the register read port shows the same error at that moment. A wrong gate bit changes bit 20 of mem_addr_o on the next DMA access. A fault in the split sequencer appears as a missing, doubled or misaddressed second byte on the memory port. It can also show as a wrong total on dma_wait_o one cycle after the last acknowledge. A faulty change detector gives either a missing strobe or a spurious strobe in the cycle right after the write.

// File: rtl/mwx_pkg.sv
package mwx_pkg;
  typedef enum logic [1:0] {
    SEL_DMA  = 2'd0,
    SEL_WIN0 = 2'd1,
    SEL_WIN1 = 2'd2,
    SEL_NONE = 2'd3
  } io_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } dma_st_e;
endpackage

// File: rtl/mwx_xlat_core.sv
module mwx_xlat_core #(
  parameter int ADDR_W   = 24,
  parameter int APER_W   = 17,
  parameter int APER0    = 4,
  parameter logic [ADDR_W-1:0] LIMIT = 24'hFA0000,
  localparam int WIN_W   = ADDR_W - APER_W
) (
  input  logic [ADDR_W-1:0] la_i,
  input  logic [WIN_W-1:0]  win0_i,
  input  logic [WIN_W-1:0]  win1_i,
  output logic [ADDR_W-1:0] pa_o,
  output logic              ok_o
);
  logic [WIN_W-1:0] idx;

  assign idx = la_i[ADDR_W-1:APER_W];

  always_comb begin
    if (idx == WIN_W'(APER0))          pa_o = {win0_i, la_i[APER_W-1:0]};
    else if (idx == WIN_W'(APER0 + 1)) pa_o = {win1_i, la_i[APER_W-1:0]};
    else                               pa_o = la_i;
    ok_o = (pa_o < LIMIT);
  end
endmodule

// File: rtl/mwx_regs.sv
module mwx_regs
  import mwx_pkg::*;
#(
  parameter int WIN_W = 7,
  parameter bit HIRES = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       io_sel_i,
  input  logic             io_wr_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  output logic [WIN_W-1:0] win0_o,
  output logic [WIN_W-1:0] win1_o,
  output logic [7:0]       gate_o,
  output logic             remap_o
);
  localparam logic [WIN_W-1:0] W0_RST = HIRES ? WIN_W'(8) : WIN_W'(4);
  localparam logic [WIN_W-1:0] W1_RST = HIRES ? WIN_W'(9) : WIN_W'(5);
  localparam logic [7:0]       G_RST  = 8'hFE;

  logic [WIN_W-1:0] win0_q, win1_q, wdat;
  logic [7:0]       gate_q;
  logic             remap_q, chg0, chg1;
  io_sel_e          sel;

  assign sel  = io_sel_e'(io_sel_i);
  assign wdat = io_wdata_i[7:8-WIN_W];
  assign chg0 = io_wr_i && (sel == SEL_WIN0) && (wdat != win0_q);
  assign chg1 = io_wr_i && (sel == SEL_WIN1) && (wdat != win1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win0_q  <= W0_RST;
      win1_q  <= W1_RST;
      gate_q  <= G_RST;
      remap_q <= 1'b0;
    end else begin
      remap_q <= chg0 | chg1;
      if (io_wr_i) begin
        case (sel)
          SEL_DMA:  gate_q <= io_wdata_i;
          SEL_WIN0: win0_q <= wdat;
          SEL_WIN1: win1_q <= wdat;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_DMA:  io_rdata_o = gate_q;
      SEL_WIN0: io_rdata_o = 8'({win0_q, 1'b0});
      SEL_WIN1: io_rdata_o = 8'({win1_q, 1'b0});
      default:  io_rdata_o = 8'h00;
    endcase
  end

  assign win0_o  = win0_q;
  assign win1_o  = win1_q;
  assign gate_o  = gate_q;
  assign remap_o = remap_q;

  // R11
  remap_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |-> $past(io_wr_i));
  // R1
  win0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> $stable(win0_q));
  // R12
  none_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_sel_i == 2'd3) |=> ($stable(gate_q) && $stable(win1_q) && !remap_o));
endmodule

// File: rtl/mwx_dma_seq.sv
module mwx_dma_seq
  import mwx_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_la_o,
  output logic              mem_wide_o,
  input  logic              mem_ack_i,
  input  logic [WAIT_W-1:0] mem_wait_i,
  output logic              done_o,
  output logic [WAIT_W:0]   wait_o
);
  dma_st_e           st_q;
  logic [ADDR_W-1:0] la_q;
  logic              wide_q, split_q, done_q;
  logic [WAIT_W:0]   sum_q, wait_q, sum_nx;

  assign sum_nx = sum_q + {1'b0, mem_wait_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      la_q    <= '0;
      wide_q  <= 1'b0;
      split_q <= 1'b0;
      done_q  <= 1'b0;
      sum_q   <= '0;
      wait_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_i) begin
          la_q    <= addr_i;
          split_q <= wide_i & addr_i[0];
          wide_q  <= wide_i & ~addr_i[0];
          sum_q   <= '0;
          st_q    <= ST_LO;
        end
        ST_LO: if (mem_ack_i) begin
          sum_q <= sum_nx;
          if (split_q) begin
            la_q <= la_q + ADDR_W'(1);
            st_q <= ST_HI;
          end else begin
            wait_q <= sum_nx;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_HI: if (mem_ack_i) begin
          wait_q <= sum_nx;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign mem_req_o  = (st_q != ST_IDLE);
  assign mem_la_o   = la_q;
  assign mem_wide_o = wide_q;
  assign done_o     = done_q;
  assign wait_o     = wait_q;

  // R10
  done_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i));
  // R9
  hi_follows_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HI) |-> ($past(st_q) == ST_LO || $past(st_q) == ST_HI));
  // R9
  hi_addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HI && $past(st_q) == ST_LO) |-> (mem_la_o == $past(mem_la_o) + ADDR_W'(1)));
endmodule

// File: rtl/mem_window_xlat.sv
module mem_window_xlat #(
  parameter int ADDR_W = 24,
  parameter int APER_W = 17,
  parameter int APER0  = 4,
  parameter logic [ADDR_W-1:0] LIMIT = 24'hFA0000,
  parameter int GATE_BIT = 20,
  parameter int WAIT_W = 4,
  parameter bit HIRES  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        io_sel_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              remap_o,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [ADDR_W-1:0] cpu_paddr_o,
  output logic              cpu_valid_o,
  input  logic              dma_req_i,
  input  logic              dma_wide_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  output logic              dma_busy_o,
  output logic              dma_done_o,
  output logic [WAIT_W:0]   dma_wait_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wide_o,
  output logic              mem_valid_o,
  input  logic              mem_ack_i,
  input  logic [WAIT_W-1:0] mem_wait_i
);
  localparam int WIN_W = ADDR_W - APER_W;
  localparam int NPORT = 2;

  logic [WIN_W-1:0]  win0, win1;
  logic [7:0]        gate;
  logic [ADDR_W-1:0] dma_la;
  logic [ADDR_W-1:0] la_a [NPORT];
  logic [ADDR_W-1:0] pa_a [NPORT];
  logic              ok_a [NPORT];
  logic              gated;

  mwx_regs #(.WIN_W(WIN_W), .HIRES(HIRES)) u_regs (
    .clk_i, .rst_ni, .io_sel_i, .io_wr_i, .io_wdata_i, .io_rdata_o,
    .win0_o(win0), .win1_o(win1), .gate_o(gate), .remap_o
  );

  mwx_dma_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dma (
    .clk_i, .rst_ni,
    .req_i(dma_req_i), .wide_i(dma_wide_i), .addr_i(dma_addr_i),
    .busy_o(dma_busy_o), .mem_req_o, .mem_la_o(dma_la), .mem_wide_o,
    .mem_ack_i, .mem_wait_i, .done_o(dma_done_o), .wait_o(dma_wait_o)
  );

  assign la_a[0] = cpu_addr_i;
  assign la_a[1] = dma_la;

  for (genvar g = 0; g < NPORT; g++) begin : g_xlat
    mwx_xlat_core #(.ADDR_W(ADDR_W), .APER_W(APER_W), .APER0(APER0), .LIMIT(LIMIT)) u_core (
      .la_i(la_a[g]), .win0_i(win0), .win1_i(win1), .pa_o(pa_a[g]), .ok_o(ok_a[g])
    );
  end

  assign gated       = gate[2];
  assign cpu_paddr_o = pa_a[0];
  assign cpu_valid_o = ok_a[0];

  always_comb begin
    mem_addr_o = pa_a[1];
    if (gated) mem_addr_o[GATE_BIT] = 1'b0;
  end
  assign mem_valid_o = ok_a[1];

  // R3
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i < ADDR_W'(APER0 << APER_W)) |-> (cpu_paddr_o == cpu_addr_i));
  // R4
  aper_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[ADDR_W-1:APER_W] == WIN_W'(APER0)) |-> (cpu_paddr_o[APER_W-1:0] == cpu_addr_i[APER_W-1:0]));
  // R8
  gate_a20_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && gated) |-> !mem_addr_o[GATE_BIT]);
endmodule

// File: tb/tb_mem_window_xlat.sv
`timescale 1ns/1ps
module tb_mem_window_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  io_sel = 2'd0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        remap;
  logic [23:0] cpu_addr = '0;
  logic [23:0] cpu_paddr;
  logic        cpu_valid;
  logic        dma_req = 1'b0, dma_wide = 1'b0;
  logic [23:0] dma_addr = '0;
  logic        dma_busy, dma_done;
  logic [4:0]  dma_wait;
  logic        mem_req, mem_wide, mem_valid;
  logic [23:0] mem_addr;
  logic        mem_ack = 1'b1;
  logic [3:0]  mem_wait;

  int checks = 0, fails = 0;
  logic [7:0] sh_w0 = 8'h08, sh_w1 = 8'h0A, sh_gate = 8'hFE;
  logic [24:0] acc_q [$];
  logic [4:0]  wait_q [$];

  always #2 clk = ~clk;

  // memory model: wait depends on the low address bits
  assign mem_wait = {2'b00, mem_addr[1:0]} + 4'd1;

  mem_window_xlat dut (
    .clk_i(clk), .rst_ni(rst_n), .io_sel_i(io_sel), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .remap_o(remap), .cpu_addr_i(cpu_addr), .cpu_paddr_o(cpu_paddr),
    .cpu_valid_o(cpu_valid), .dma_req_i(dma_req), .dma_wide_i(dma_wide), .dma_addr_i(dma_addr),
    .dma_busy_o(dma_busy), .dma_done_o(dma_done), .dma_wait_o(dma_wait), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_wide_o(mem_wide), .mem_valid_o(mem_valid), .mem_ack_i(mem_ack),
    .mem_wait_i(mem_wait)
  );

  function automatic logic [23:0] model_pa(input logic [23:0] la);
    if (la < 24'h080000)      return la;
    else if (la < 24'h0A0000) return (la & 24'h01FFFF) | ({16'h0, sh_w0 & 8'hFE} << 16);
    else if (la < 24'h0C0000) return (la & 24'h01FFFF) | ({16'h0, sh_w1 & 8'hFE} << 16);
    else                      return la;
  endfunction

  function automatic logic [23:0] model_dma(input logic [23:0] la);
    logic [23:0] p;
    p = model_pa(la);
    if (sh_gate[2]) p[20] = 1'b0;
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [1:0] sel, input logic [7:0] d, output logic rm);
    @(negedge clk);
    io_sel = sel; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    rm = remap;
  endtask

  task automatic io_read(input logic [1:0] sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    io_sel = sel;
    #1 check(req, {24'h0, io_rdata}, {24'h0, exp});
  endtask

  task automatic cpu_chk(input logic [23:0] la, input string req);
    logic [23:0] e;
    @(negedge clk);
    cpu_addr = la;
    e = model_pa(la);
    #1;
    check(req, {8'h0, cpu_paddr}, {8'h0, e});
    check("R7", {31'h0, cpu_valid}, {31'h0, (e < 24'hFA0000)});
  endtask

  // driver: pushes expected accesses, then issues the request
  task automatic dma_xfer(input logic [23:0] la, input logic wide);
    logic [23:0] a0, a1;
    logic [4:0] s;
    a0 = model_dma(la);
    if (wide && la[0]) begin
      a1 = model_dma(la + 24'd1);
      acc_q.push_back({1'b0, a0});
      acc_q.push_back({1'b0, a1});
      s = 5'(a0[1:0]) + 5'd1 + 5'(a1[1:0]) + 5'd1;
    end else begin
      acc_q.push_back({wide, a0});
      s = 5'(a0[1:0]) + 5'd1;
    end
    wait_q.push_back(s);
    @(negedge clk);
    dma_addr = la; dma_wide = wide; dma_req = 1'b1;
    @(negedge clk);
    dma_req = 1'b0;
    while (dma_busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares memory accesses and completions against the queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        logic [24:0] e;
        if (acc_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9 actual=%0h expected=none", {mem_wide, mem_addr});
        end else begin
          e = acc_q.pop_front();
          check("R9/R8", {7'h0, mem_wide, mem_addr}, {7'h0, e});
        end
      end
      if (dma_done) begin
        if (wait_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 actual=%0h expected=none", dma_wait);
        end else check("R10", {27'h0, dma_wait}, {27'h0, wait_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic rm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2, R12 reset values
    io_read(2'd0, 8'hFE, "R2");
    io_read(2'd1, 8'h08, "R2");
    io_read(2'd2, 8'h0A, "R2");
    io_read(2'd3, 8'h00, "R12");
    check("R11", {31'h0, remap}, 32'h0);
    // R3, R4, R5 with default bases
    cpu_chk(24'h000000, "R3");
    cpu_chk(24'h07FFFF, "R3");
    cpu_chk(24'h09ABCD, "R4");
    cpu_chk(24'h0A1234, "R5");
    // R1, R11: bit 0 ignored, same base -> no strobe
    io_write(2'd1, 8'h09, rm);
    check("R11", {31'h0, rm}, 32'h0);
    io_read(2'd1, 8'h08, "R1");
    // R11: change -> one-cycle strobe
    io_write(2'd1, 8'h31, rm); sh_w0 = 8'h31;
    check("R11", {31'h0, rm}, 32'h1);
    @(negedge clk);
    check("R11", {31'h0, remap}, 32'h0);
    io_read(2'd1, 8'h30, "R1");
    cpu_chk(24'h09ABCD, "R4");
    cpu_chk(24'h080000, "R4");
    io_write(2'd2, 8'h42, rm); sh_w1 = 8'h42;
    check("R11", {31'h0, rm}, 32'h1);
    cpu_chk(24'h0BFFFF, "R5");
    cpu_chk(24'h0A0000, "R5");
    // R6, R7 passthrough and cutoff
    cpu_chk(24'h0C0000, "R6");
    cpu_chk(24'hF9FFFF, "R6");
    cpu_chk(24'hFA0000, "R7");
    cpu_chk(24'hFFFFFF, "R7");
    io_write(2'd1, 8'hFC, rm); sh_w0 = 8'hFC;
    cpu_chk(24'h080000, "R7");
    io_write(2'd1, 8'hF8, rm); sh_w0 = 8'hF8;
    cpu_chk(24'h09FFFF, "R7");
    // R12: code 3 writes change nothing
    io_write(2'd3, 8'h00, rm);
    check("R12", {31'h0, rm}, 32'h0);
    io_read(2'd0, 8'hFE, "R12");
    io_read(2'd1, 8'hF8, "R12");
    io_read(2'd2, 8'h42, "R12");
    // R8, R9, R10: gated DMA, odd word split across a boundary
    dma_xfer(24'h1FFFFF, 1'b1);
    io_write(2'd0, 8'h00, rm); sh_gate = 8'h00;
    io_read(2'd0, 8'h00, "R8");
    dma_xfer(24'h100010, 1'b1);
    dma_xfer(24'h1FFFFF, 1'b0);
    dma_xfer(24'h09FFFF, 1'b1);
    io_write(2'd0, 8'h04, rm); sh_gate = 8'h04;
    io_read(2'd0, 8'h04, "R8");
    dma_xfer(24'h300005, 1'b0);
    dma_xfer(24'h100003, 1'b1);
    repeat (3) @(negedge clk);
    check("R9", acc_q.size(), 32'h0);
    check("R10", wait_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule